// File: doc/BRIEF.md
# Key-Guarded Real-Time Clock with Seconds Alarm

This block keeps wall time as a 32-bit seconds count extended by an 8-bit fraction of a second. A reference tick input drives a prescaler, so the fraction advances once every `PRESC` ticks. When the fraction wraps from 255 to 0, the seconds count increments. A seconds alarm compares the full seconds count against a programmed value. On a match it sets a sticky status flag and raises a one-cycle wake request.

Software reaches the block through a plain write port made of an address, a data word and a strobe. The port has no back-pressure: every strobed write completes in the cycle it is presented. Four registers sit behind it: control, count, alarm and status.

The run bit, the alarm-enable bit, the count register and the alarm register are each guarded by a key bit in the control register. A guarded write is accepted only if its key already held 1 before that write. Unlocking therefore always takes two writes. The remaining control bits can be written at any time, whatever the keys hold.

Top module: `rtc_guarded`

## Requirements
- R1: After reset, `ctrl_bits` reads 6'b110001, and the seconds count, fraction, alarm value, `alarm_flag` and `wake_req` are all zero. The control encoding is: bit0 run, bit1 count key, bit2 alarm enable, bit3 alarm key, bit4 oscillator enable, bit5 loop enable.
- R2: While run is 1, the fraction advances by one on every `PRESC`-th tick. When the fraction steps from 255 to 0, the seconds count increments in the same clock.
- R3: While run is 0, ticks are ignored and both count fields hold their values.
- R4: A write to the control register (address 0) changes run only if the count key was already 1. A write to the count register (address 1) is ignored unless the count key was already 1. Setting the key and run in the same write leaves run unchanged.
- R5: A write to the control register changes alarm enable only if the alarm key was already 1. A write to the alarm register (address 2, data bits [31:0]) is ignored unless the alarm key was already 1.
- R6: Bits 1, 3, 4 and 5 of the control register take the written value on every control write, regardless of the keys.
- R7: An accepted count write loads seconds from data [39:8] and the fraction from data [7:0], and it clears the prescaler. The next fraction step therefore needs a full `PRESC` ticks.
- R8: When alarm enable is 1 and the seconds count becomes equal to the alarm value, `alarm_flag` rises and `wake_req` pulses for exactly one cycle. Both appear on the clock edge after the seconds change.
- R9: `alarm_flag` stays set until a write to the status register (address 3) with data bit 0 set. A status write with bit 0 clear leaves the flag set. A match that is still ongoing does not set the flag again.
- R10: While alarm enable is 0, a match of the seconds count sets neither `alarm_flag` nor `wake_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Reference tick, one cycle per pulse |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | SEC_W+SUB_W | Write data |
| sec_count | output | SEC_W | Seconds count |
| sub_count | output | SUB_W | Fraction of a second |
| alarm_sec | output | SEC_W | Programmed alarm value |
| ctrl_bits | output | 6 | Control register contents |
| alarm_flag | output | 1 | Sticky alarm status |
| wake_req | output | 1 | One-cycle wake request |

## Verification
Several internal faults show up on the outputs immediately:
- A key sampled after the write instead of before it shows on `ctrl_bits` or `sec_count` in the cycle after a single combined write.
- A prescaler left uncleared by a load shows one tick early on `sub_count`.
- A missed wrap from the fraction into the seconds count is visible within one second of ticks.

An alarm that compares the wrong value, re-arms during an ongoing match, or ignores its enable shows on `alarm_flag` and `wake_req` within two clocks of the seconds change.

// File: rtl/rtc_guard_pkg.sv
package rtc_guard_pkg;

  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL   = 2'd0,
    A_COUNT  = 2'd1,
    A_ALARM  = 2'd2,
    A_STATUS = 2'd3
  } reg_addr_e;

  localparam int CB_RUN  = 0;
  localparam int CB_RKEY = 1;
  localparam int CB_AEN  = 2;
  localparam int CB_AKEY = 3;
  localparam int CB_OSC  = 4;
  localparam int CB_FLL  = 5;
  localparam int CTRL_W  = 6;

  typedef struct packed {
    logic fll;
    logic osc;
    logic akey;
    logic aen;
    logic rkey;
    logic run;
  } ctrl_t;

  localparam logic [CTRL_W-1:0] CTRL_RST = 6'b110001;

endpackage

// File: rtl/rtc_regs.sv
module rtc_regs
  import rtc_guard_pkg::*;
#(
  parameter int SEC_W = 32,
  parameter int REG_W = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  output ctrl_t             ctrl_q,
  output logic [SEC_W-1:0]  alarm_q,
  output logic              load_o,
  output logic              clr_flag_o
);

  logic hit_ctrl, hit_alarm;

  // Guards always look at the key held before the current write.
  assign hit_ctrl   = wr_en && (wr_addr == A_CTRL);
  assign hit_alarm  = wr_en && (wr_addr == A_ALARM) && ctrl_q.akey;
  assign load_o     = wr_en && (wr_addr == A_COUNT) && ctrl_q.rkey;
  assign clr_flag_o = wr_en && (wr_addr == A_STATUS) && wr_data[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= ctrl_t'(CTRL_RST);
    end else if (hit_ctrl) begin
      ctrl_q.rkey <= wr_data[CB_RKEY];
      ctrl_q.akey <= wr_data[CB_AKEY];
      ctrl_q.osc  <= wr_data[CB_OSC];
      ctrl_q.fll  <= wr_data[CB_FLL];
      if (ctrl_q.rkey) ctrl_q.run <= wr_data[CB_RUN];
      if (ctrl_q.akey) ctrl_q.aen <= wr_data[CB_AEN];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         alarm_q <= '0;
    else if (hit_alarm) alarm_q <= wr_data[SEC_W-1:0];
  end

endmodule

// File: rtl/rtc_count.sv
module rtc_count #(
  parameter int SEC_W = 32,
  parameter int SUB_W = 8,
  parameter int PRESC = 128,
  localparam int REG_W = SEC_W + SUB_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             load,
  input  logic [REG_W-1:0] load_val,
  output logic [SEC_W-1:0] sec_q,
  output logic [SUB_W-1:0] sub_q
);

  logic step;

  generate
    if (PRESC > 1) begin : g_presc
      localparam int PW = $clog2(PRESC);
      logic [PW-1:0] presc_q;
      logic          presc_end;
      assign presc_end = (presc_q == PW'(PRESC - 1));
      assign step      = run && tick && presc_end;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           presc_q <= '0;
        else if (load)        presc_q <= '0;
        else if (run && tick) presc_q <= presc_end ? '0 : presc_q + 1'b1;
      end
    end else begin : g_direct
      assign step = run && tick;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q <= '0;
      sub_q <= '0;
    end else if (load) begin
      sec_q <= load_val[REG_W-1:SUB_W];
      sub_q <= load_val[SUB_W-1:0];
    end else if (step) begin
      sub_q <= sub_q + 1'b1;
      if (&sub_q) sec_q <= sec_q + 1'b1;
    end
  end

endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm #(
  parameter int SEC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [SEC_W-1:0] sec,
  input  logic [SEC_W-1:0] alarm,
  input  logic             clr,
  output logic             flag_q,
  output logic             wake_q
);

  logic match, match_d, evt;

  assign match = en && (sec == alarm);
  assign evt   = match && !match_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_d <= 1'b0;
      flag_q  <= 1'b0;
      wake_q  <= 1'b0;
    end else begin
      match_d <= match;
      wake_q  <= evt;
      if (evt)      flag_q <= 1'b1;
      else if (clr) flag_q <= 1'b0;
    end
  end

endmodule

// File: rtl/rtc_guarded.sv
module rtc_guarded
  import rtc_guard_pkg::*;
#(
  parameter int SEC_W = 32,
  parameter int SUB_W = 8,
  parameter int PRESC = 128,
  localparam int REG_W = SEC_W + SUB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  output logic [SEC_W-1:0]  sec_count,
  output logic [SUB_W-1:0]  sub_count,
  output logic [SEC_W-1:0]  alarm_sec,
  output logic [CTRL_W-1:0] ctrl_bits,
  output logic              alarm_flag,
  output logic              wake_req
);

  ctrl_t ctrl;
  logic  load, clr_flag;

  rtc_regs #(.SEC_W(SEC_W), .REG_W(REG_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .ctrl_q     (ctrl),
    .alarm_q    (alarm_sec),
    .load_o     (load),
    .clr_flag_o (clr_flag)
  );

  rtc_count #(.SEC_W(SEC_W), .SUB_W(SUB_W), .PRESC(PRESC)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (ctrl.run),
    .tick     (tick),
    .load     (load),
    .load_val (wr_data),
    .sec_q    (sec_count),
    .sub_q    (sub_count)
  );

  rtc_alarm #(.SEC_W(SEC_W)) u_alarm (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (ctrl.aen),
    .sec    (sec_count),
    .alarm  (alarm_sec),
    .clr    (clr_flag),
    .flag_q (alarm_flag),
    .wake_q (wake_req)
  );

  assign ctrl_bits = ctrl;

endmodule

// File: rtl/rtc_guarded_chk.sv
module rtc_guarded_chk
  import rtc_guard_pkg::*;
#(
  parameter int SEC_W = 32,
  parameter int SUB_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [SEC_W-1:0]  sec_count,
  input logic [SUB_W-1:0]  sub_count,
  input logic [SEC_W-1:0]  alarm_sec,
  input logic [CTRL_W-1:0] ctrl_bits,
  input logic              alarm_flag,
  input logic              wake_req
);

  logic wr_ctrl, wr_cnt, wr_alm, wr_stat;
  assign wr_ctrl = wr_en && (wr_addr == A_CTRL);
  assign wr_cnt  = wr_en && (wr_addr == A_COUNT);
  assign wr_alm  = wr_en && (wr_addr == A_ALARM);
  assign wr_stat = wr_en && (wr_addr == A_STATUS);

  // R2: seconds move only when the fraction wraps
  a_r2_sec_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_cnt && (sub_count != {SUB_W{1'b1}})) |=> $stable(sec_count));

  // R3: stopped clock holds both fields
  a_r3_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_bits[CB_RUN] && !wr_cnt) |=> ($stable(sec_count) && $stable(sub_count)));

  // R4: run bit locked without a prior count key
  a_r4_run_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_bits[CB_RKEY]) |=> $stable(ctrl_bits[CB_RUN]));

  // R4: count register locked without a prior count key
  a_r4_count_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cnt && !ctrl_bits[CB_RKEY] && !ctrl_bits[CB_RUN]) |=> ($stable(sec_count) && $stable(sub_count)));

  // R5: alarm enable and alarm value locked without a prior alarm key
  a_r5_alarm_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_bits[CB_AKEY]) |=> ($stable(ctrl_bits[CB_AEN]) && $stable(alarm_sec)));

  // R8: wake request is a single-cycle pulse accompanied by the flag
  a_r8_wake_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |=> !wake_req);
  a_r8_wake_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> alarm_flag);

  // R9: flag is sticky until a status write
  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_flag && !wr_stat) |=> alarm_flag);

  // R10: disabled alarm never raises the flag
  a_r10_no_flag_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_bits[CB_AEN] && !alarm_flag) |=> !alarm_flag);

  // R6 has no separate property: it is checked only by the bench
  logic unused_ok;
  assign unused_ok = wr_ctrl ^ wr_alm;

endmodule

bind rtc_guarded rtc_guarded_chk #(.SEC_W(SEC_W), .SUB_W(SUB_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .sec_count  (sec_count),
  .sub_count  (sub_count),
  .alarm_sec  (alarm_sec),
  .ctrl_bits  (ctrl_bits),
  .alarm_flag (alarm_flag),
  .wake_req   (wake_req)
);

// File: tb/tb_rtc_guarded.sv
`timescale 1ns/1ps
module tb_rtc_guarded;

  localparam int SEC_W = 32;
  localparam int SUB_W = 8;
  localparam int PRESC = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              tick = 1'b0;
  logic              wr_en = 1'b0;
  logic [1:0]        wr_addr = '0;
  logic [39:0]       wr_data = '0;
  logic [SEC_W-1:0]  sec_count, alarm_sec;
  logic [SUB_W-1:0]  sub_count;
  logic [5:0]        ctrl_bits;
  logic              alarm_flag, wake_req;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  rtc_guarded #(.SEC_W(SEC_W), .SUB_W(SUB_W), .PRESC(PRESC)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sec_count(sec_count), .sub_count(sub_count),
    .alarm_sec(alarm_sec), .ctrl_bits(ctrl_bits), .alarm_flag(alarm_flag),
    .wake_req(wake_req)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [39:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wctrl(input logic run, rkey, aen, akey, osc, fll);
    wr(2'd0, {34'd0, fll, osc, akey, aen, rkey, run});
  endtask

  task automatic load(input logic [31:0] s, input logic [7:0] f);
    wr(2'd1, {s, f});
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
    end
    tick = 1'b0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 ctrl", ctrl_bits, 6'b110001);
    chk("R1 sec", sec_count, 0);
    chk("R1 sub", sub_count, 0);
    chk("R1 alarm", alarm_sec, 0);
    chk("R1 flag", {alarm_flag, wake_req}, 0);
  endtask

  task automatic t_count_key();
    load(32'd100, 8'd0);
    chk("R4 count write without key", sec_count, 0);
    wctrl(0, 1, 0, 0, 1, 1);
    chk("R4 key and run in one write", ctrl_bits, 6'b110011);
    wctrl(0, 1, 0, 0, 1, 1);
    chk("R4 run after unlock", ctrl_bits, 6'b110010);
    load(32'd5, 8'd3);
    chk("R7 load sec", sec_count, 5);
    chk("R7 load sub", sub_count, 3);
  endtask

  task automatic t_hold();
    ticks(10);
    chk("R3 hold sec", sec_count, 5);
    chk("R3 hold sub", sub_count, 3);
  endtask

  task automatic t_count();
    wctrl(1, 1, 0, 0, 1, 1);
    load(32'd7, 8'd0);
    ticks(1);
    chk("R2 half prescale", sub_count, 0);
    ticks(1);
    chk("R2 first step", sub_count, 1);
    ticks(508);
    chk("R2 sub at 255", {sec_count, sub_count}, {32'd7, 8'd255});
    ticks(2);
    chk("R2 wrap into sec", {sec_count, sub_count}, {32'd8, 8'd0});
    ticks(1);
    load(32'd8, 8'd10);
    ticks(1);
    chk("R7 prescaler cleared", sub_count, 10);
    ticks(1);
    chk("R7 step after full prescale", sub_count, 11);
  endtask

  task automatic t_alarm_key();
    wr(2'd2, 40'd50);
    chk("R5 alarm write without key", alarm_sec, 0);
    wctrl(1, 1, 1, 1, 1, 1);
    chk("R5 key and enable in one write", ctrl_bits, 6'b111011);
    wr(2'd2, 40'd11);
    chk("R5 alarm write with key", alarm_sec, 11);
    wctrl(1, 1, 1, 1, 1, 1);
    chk("R5 enable after unlock", ctrl_bits, 6'b111111);
  endtask

  task automatic t_alarm();
    load(32'd10, 8'd254);
    ticks(4);
    chk("R8 seconds reached", {sec_count, sub_count}, {32'd11, 8'd0});
    chk("R8 not yet flagged", {alarm_flag, wake_req}, 2'b00);
    step();
    chk("R8 flag and wake", {alarm_flag, wake_req}, 2'b11);
    step();
    chk("R8 wake one cycle", {alarm_flag, wake_req}, 2'b10);
  endtask

  task automatic t_sticky();
    wr(2'd3, 40'd0);
    chk("R9 zero write keeps flag", alarm_flag, 1);
    wr(2'd3, 40'd1);
    chk("R9 clear", alarm_flag, 0);
    step();
    chk("R9 no re-set during match", {alarm_flag, wake_req}, 2'b00);
  endtask

  task automatic t_disabled();
    wctrl(1, 1, 0, 1, 1, 1);
    load(32'd10, 8'd254);
    ticks(4);
    step();
    step();
    chk("R10 sec matched", sec_count, 11);
    chk("R10 no flag", {alarm_flag, wake_req}, 2'b00);
  endtask

  task automatic t_free_bits();
    wctrl(0, 0, 0, 0, 0, 0);
    chk("R6 all cleared", ctrl_bits, 6'b000000);
    wctrl(1, 0, 1, 0, 1, 1);
    chk("R6 free bits set, guarded held", ctrl_bits, 6'b110000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_count_key();
    t_hold();
    t_count();
    t_alarm_key();
    t_alarm();
    t_sticky();
    t_disabled();
    t_free_bits();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule